// File: doc/BRIEF.md
# Delay-Matched Multiply-Subtract Element

This block is one processing element of a pipelined elimination stage, placed below the pivot row. For each operation it computes `cur - q * col`. Here `cur` is the element's own value, `col` is the value in the pivot column of the same row, and `q` is the quotient that an upstream divider produced from the pivot row. The values `cur` and `col` arrive together with the matrix at the stage. The quotient arrives `DIV_LAT` cycles later on its own port, with no valid signal of its own.

Two internal delay lines absorb that skew. The pivot-column value waits `DIV_LAT` cycles so that it meets its quotient at the multiplier. The element's own value waits `DIV_LAT + MUL_LAT` cycles so that it meets the product at the subtractor. Multiply and subtract are separate register pipelines, so a new operand set can be issued on every cycle. The total latency is `DIV_LAT + MUL_LAT + 1`, which equals the latency of a forward-only element in the same stage.

Data is signed fixed point with `DATA_W` bits, of which `FRAC_W` are fractional. The product drops its fractional bits by arithmetic truncation, which rounds toward minus infinity. Each result is then placed in one of three clip classes:
- `CLIP_PASS`: the difference is in range.
- `CLIP_HIGH`: the difference is above the largest code.
- `CLIP_LOW`: the difference is below the smallest code.

The class is picked fresh on every cycle, with no history. The only transitions are the per-cycle moves between these three classes.

Top module: `msub_elem`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `valid_out` is 0 and `res_out` is 0.
- R2: An operation issued with `valid_in`=1 in cycle k, together with the `quot_in` value presented in cycle k+DIV_LAT, yields `res_out = cur_in - floor(quot_in*col_in / 2^FRAC_W)`, clipped to DATA_W-bit two's complement.
- R3: The product is reduced by an arithmetic right shift of FRAC_W bits. A product of -1 LSB² therefore becomes -1, and a product of +1 LSB² becomes 0.
- R4: `valid_out` rises exactly DIV_LAT+MUL_LAT+1 cycles after the matching `valid_in`, and is never high within the first DIV_LAT+MUL_LAT+1 cycles after reset.
- R5: A difference above 2^(DATA_W-1)-1 gives 0x7FFF (CLIP_HIGH). A difference below -2^(DATA_W-1) gives 0x8000 (CLIP_LOW), both for DATA_W=16.
- R6: Valid inputs on consecutive cycles give valid outputs on consecutive cycles, each with its own correct result. No more than DIV_LAT+MUL_LAT+1 operations are ever in flight.
- R7: Cycles with `valid_in`=0 give `valid_out`=0 at the matching output cycle, whatever values the data ports carry. Those values do not disturb the results of neighbouring valid operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operation issue strobe, cycle of matrix arrival |
| cur_in | input | DATA_W | Element's own value (minuend) |
| col_in | input | DATA_W | Pivot-column value of the same row |
| quot_in | input | DATA_W | Quotient, presented DIV_LAT cycles after issue |
| valid_out | output | 1 | Result valid |
| res_out | output | DATA_W | Saturated difference |

## Verification
Within a single cycle, the element both accepts a fresh `cur`/`col` pair and consumes, on `quot_in`, the quotient that belongs to an operation issued DIV_LAT cycles earlier. The bench provokes this by streaming valid operations back to back and by interleaving idle slots that carry garbage data. In both cases the quotient port holds the value of an older operation while the data ports hold a newer one. Each result is compared with a model that pairs operands purely by issue index, so any skew in either delay line shows up as a wrong result or a misplaced `valid_out`.

// File: rtl/msub_pkg.sv
package msub_pkg;
    typedef enum logic [1:0] {
        CLIP_PASS = 2'd0,
        CLIP_HIGH = 2'd1,
        CLIP_LOW  = 2'd2
    } clip_e;
endpackage

// File: rtl/msub_delay.sv
module msub_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] tap [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
        end else begin
            tap[0] <= d;
            for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
        end
    end

    assign q = tap[DEPTH-1];
endmodule

// File: rtl/msub_mult.sv
module msub_mult #(
    parameter int W      = 16,
    parameter int F      = 8,
    parameter int STAGES = 2,
    localparam int PW    = 2*W - F
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vin,
    input  logic signed [W-1:0]  a,
    input  logic signed [W-1:0]  b,
    output logic                 vout,
    output logic signed [PW-1:0] p
);
    logic signed [2*W-1:0] full_p;
    logic signed [2*W-1:0] shifted;
    logic                  v1;
    logic signed [PW-1:0]  p1;

    assign full_p  = a * b;
    assign shifted = full_p >>> F;

    // first register stage: product with fraction dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            p1 <= '0;
        end else begin
            v1 <= vin;
            p1 <= shifted[PW-1:0];
        end
    end

    generate
        if (STAGES > 1) begin : g_tail
            logic [PW:0] tail_q;
            msub_delay #(.W(PW+1), .DEPTH(STAGES-1)) u_tail (
                .clk(clk), .rst(rst), .d({v1, p1}), .q(tail_q)
            );
            assign vout = tail_q[PW];
            assign p    = $signed(tail_q[PW-1:0]);
        end else begin : g_direct
            assign vout = v1;
            assign p    = p1;
        end
    endgenerate

    // R3: the registered product is the floor of the exact product
    logic signed [2*W-1:0] back;
    localparam logic signed [2*W-1:0] FSCALE = (2*W)'(1) << F;
    assign back = {p1, {F{1'b0}}};

    a_r3_floor_product: assert property (@(posedge clk) disable iff (rst)
        v1 |-> (($past(full_p) - back) >= 0) && (($past(full_p) - back) < FSCALE));
endmodule

// File: rtl/msub_satsub.sv
module msub_satsub
    import msub_pkg::*;
#(
    parameter int W  = 16,
    parameter int PW = 24,
    localparam int SW = PW + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vin,
    input  logic signed [W-1:0]  a,
    input  logic signed [PW-1:0] b,
    output logic                 vout,
    output logic signed [W-1:0]  res
);
    localparam logic signed [SW-1:0] HI = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [SW-1:0] LO = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [SW-1:0] ax, bx, diff;
    clip_e                cls;

    assign ax   = {{(SW-W){a[W-1]}}, a};
    assign bx   = {b[PW-1], b};
    assign diff = ax - bx;

    always_comb begin
        if (diff > HI)      cls = CLIP_HIGH;
        else if (diff < LO) cls = CLIP_LOW;
        else                cls = CLIP_PASS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vout <= 1'b0;
            res  <= '0;
        end else begin
            vout <= vin;
            unique case (cls)
                CLIP_HIGH: res <= HI[W-1:0];
                CLIP_LOW:  res <= LO[W-1:0];
                default:   res <= diff[W-1:0];
            endcase
        end
    end

    // R5: a clipped code only appears when the difference was out of range
    a_r5_clip_high_cause: assert property (@(posedge clk) disable iff (rst)
        (vout && res == HI[W-1:0]) |-> ($past(diff) >= HI));
    a_r5_clip_low_cause: assert property (@(posedge clk) disable iff (rst)
        (vout && res == LO[W-1:0]) |-> ($past(diff) <= LO));
    // R2: in-range differences pass unchanged
    a_r2_pass_exact: assert property (@(posedge clk) disable iff (rst)
        (vin && diff <= HI && diff >= LO) |=> (res == $past(diff[W-1:0])));
endmodule

// File: rtl/msub_elem.sv
module msub_elem #(
    parameter int DATA_W  = 16,
    parameter int FRAC_W  = 8,
    parameter int DIV_LAT = 4,
    parameter int MUL_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [DATA_W-1:0] cur_in,
    input  logic [DATA_W-1:0] col_in,
    input  logic [DATA_W-1:0] quot_in,
    output logic              valid_out,
    output logic [DATA_W-1:0] res_out
);
    localparam int PW  = 2*DATA_W - FRAC_W;
    localparam int TOT = DIV_LAT + MUL_LAT + 1;
    localparam int CW  = $clog2(TOT + 2) + 1;

    logic [DATA_W:0]          col_q;
    logic [DATA_W-1:0]        cur_q;
    logic                     mul_v;
    logic signed [PW-1:0]     mul_p;
    logic signed [DATA_W-1:0] sub_res;

    // pivot-column operand waits for its quotient
    msub_delay #(.W(DATA_W+1), .DEPTH(DIV_LAT)) u_col_dly (
        .clk(clk), .rst(rst), .d({valid_in, col_in}), .q(col_q)
    );

    // minuend waits for the product
    msub_delay #(.W(DATA_W), .DEPTH(DIV_LAT+MUL_LAT)) u_cur_dly (
        .clk(clk), .rst(rst), .d(cur_in), .q(cur_q)
    );

    msub_mult #(.W(DATA_W), .F(FRAC_W), .STAGES(MUL_LAT)) u_mul (
        .clk(clk), .rst(rst), .vin(col_q[DATA_W]),
        .a($signed(quot_in)), .b($signed(col_q[DATA_W-1:0])),
        .vout(mul_v), .p(mul_p)
    );

    msub_satsub #(.W(DATA_W), .PW(PW)) u_sub (
        .clk(clk), .rst(rst), .vin(mul_v),
        .a($signed(cur_q)), .b(mul_p),
        .vout(valid_out), .res(sub_res)
    );

    assign res_out = sub_res;

    // occupancy and fill counters for the timing checks
    logic [CW-1:0] inflight;
    logic [CW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            inflight  <= '0;
            since_rst <= '0;
        end else begin
            inflight <= inflight + CW'(valid_in) - CW'(valid_out);
            if (since_rst < CW'(TOT)) since_rst <= since_rst + 1'b1;
        end
    end

    a_r4_no_early_valid: assert property (@(posedge clk) disable iff (rst)
        (since_rst < CW'(TOT)) |-> !valid_out);
    a_r6_inflight_bound: assert property (@(posedge clk) disable iff (rst)
        inflight <= CW'(TOT));
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!valid_out && res_out == '0));
endmodule

// File: tb/sim_msub_elem.sv
`timescale 1ns/1ps
module sim_msub_elem;
    localparam int DW   = 16;
    localparam int FW   = 8;
    localparam int DL   = 4;
    localparam int ML   = 2;
    localparam int TOT  = DL + ML + 1;
    localparam int NMAX = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_in = 1'b0;
    logic [DW-1:0] cur_in = '0, col_in = '0, quot_in = '0;
    logic          valid_out;
    logic [DW-1:0] res_out;

    int n_chk  = 0;
    int n_fail = 0;

    logic          sv [NMAX];
    logic [DW-1:0] sc [NMAX];
    logic [DW-1:0] so [NMAX];
    logic [DW-1:0] sq [NMAX];

    always #10 clk = ~clk;

    msub_elem #(.DATA_W(DW), .FRAC_W(FW), .DIV_LAT(DL), .MUL_LAT(ML)) u0 (
        .clk(clk), .rst(rst), .valid_in(valid_in), .cur_in(cur_in),
        .col_in(col_in), .quot_in(quot_in),
        .valid_out(valid_out), .res_out(res_out)
    );

    function automatic logic [DW-1:0] model(logic [DW-1:0] c, logic [DW-1:0] q, logic [DW-1:0] o);
        longint p, d;
        p = longint'($signed(q)) * longint'($signed(o));
        p = p >>> FW;
        d = longint'($signed(c)) - p;
        if (d > 32767)  d = 32767;
        if (d < -32768) d = -32768;
        return DW'(d);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_slots();
        for (int i = 0; i < NMAX; i++) begin
            sv[i] = 1'b0; sc[i] = '0; so[i] = '0; sq[i] = '0;
        end
    endtask

    task automatic put(input int i, input logic [DW-1:0] c, input logic [DW-1:0] q, input logic [DW-1:0] o);
        sv[i] = 1'b1; sc[i] = c; sq[i] = q; so[i] = o;
    endtask

    // Sample at each falling edge, then drive the next slot.
    task automatic run_stream(input int n, input string tag);
        for (int t = 0; t < n + TOT + 1; t++) begin
            @(negedge clk);
            begin
                int  k;
                logic ev;
                k  = t - TOT;
                ev = (k >= 0 && k < n) ? sv[k] : 1'b0;
                chk(valid_out == ev, (ev ? "R4 valid timing" : "R7 idle slot"), valid_out, ev);
                if (ev) begin
                    logic [DW-1:0] e;
                    e = model(sc[k], sq[k], so[k]);
                    chk(res_out == e, tag, res_out, e);
                end
            end
            valid_in = (t < n) ? sv[t] : 1'b0;
            cur_in   = (t < n) ? sc[t] : '0;
            col_in   = (t < n) ? so[t] : '0;
            quot_in  = (t >= DL && t - DL < n) ? sq[t-DL] : '0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(valid_out == 1'b0, "R1 valid in reset", valid_out, 0);
        chk(res_out == '0, "R1 result in reset", res_out, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(valid_out == 1'b0 && res_out == '0, "R1 after reset", res_out, 0);
    endtask

    task automatic t_basic();
        clear_slots();
        put(0, 16'h0300, 16'h0080, 16'h0200);  // 3 - 0.5*2 = 2
        put(3, 16'hFE00, 16'h0100, 16'h0100);  // -2 - 1 = -3
        put(5, 16'h0000, 16'hFF00, 16'h0280);  // 0 + 2.5
        run_stream(8, "R2 basic result");
    endtask

    task automatic t_trunc();
        clear_slots();
        put(0, 16'h0000, 16'hFFFF, 16'h0001);  // -1 lsb^2 -> -1 -> result 1
        put(1, 16'h0010, 16'h0001, 16'h0001);  // +1 lsb^2 -> 0 -> result 0x10
        put(2, 16'h0000, 16'hFFFF, 16'h00FF);  // -255 -> -1
        run_stream(4, "R3 truncation");
    endtask

    task automatic t_sat();
        clear_slots();
        put(0, 16'h7F00, 16'h8000, 16'h0100);  // high clip
        put(1, 16'h8100, 16'h7FFF, 16'h7FFF);  // low clip
        put(2, 16'h7FFF, 16'h0000, 16'h1234);  // exact maximum, no clip
        run_stream(4, "R5 saturation");
    endtask

    task automatic t_b2b();
        clear_slots();
        for (int i = 0; i < 40; i++)
            put(i, DW'(i*2741 + 1234), DW'(i*613 + 77), DW'(i*389 + 5));
        run_stream(40, "R6 back-to-back");
    endtask

    task automatic t_gaps();
        clear_slots();
        for (int i = 0; i < 30; i++) begin
            if (i % 3 == 1) begin
                sv[i] = 1'b0; sc[i] = 16'hDEAD; so[i] = 16'h7777; sq[i] = 16'h8001;
            end else begin
                put(i, DW'(i*97 + 300), DW'(i*31 - 200), DW'(i*53 + 9));
            end
        end
        run_stream(30, "R7 gaps");
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_basic();
        t_trunc();
        t_sat();
        t_b2b();
        t_gaps();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule